// File: doc/BRIEF.md
# CAN Bit Timing and Receive Sampler

This block turns a master clock into CAN bit timing and samples the serial receive line once per bit. A prescaler divides the master clock into time quanta. Each bit period is built from a one-quantum sync segment, a propagation segment, a first phase segment and a second phase segment. The sample point sits at the end of the first phase segment. At each sample point the block emits a one-cycle strobe together with the sampled bit value.

The block waits after being enabled. It locks onto the bit grid at the first recessive-to-dominant transition it sees, which is a hard synchronization. After that it follows the remote transmitter by resynchronizing on later recessive-to-dominant transitions. A late transition stretches the first phase segment and an early one trims the second, never by more than the jump width. The sampling can take one sample per bit or three samples per bit resolved by majority. The configuration is captured only while the block is disabled. Frame decoding, stuffing, arbitration and transmit logic belong to the surrounding controller.

Top module: `can_bit_timer`

## Requirements
- R1: A time quantum lasts (cfg_brp+1) clock cycles. Without resynchronization a bit period lasts (cfg_prop+cfg_ph1+cfg_ph2+4) quanta: 1 sync, cfg_prop+1 propagation, cfg_ph1+1 phase-1 and cfg_ph2+1 phase-2 quanta.
- R2: The sample point is the clock edge that ends phase segment 1. sample_valid is high for exactly one cycle, starting at the clock edge after the sample point.
- R3: After enable rises, no sample_valid appears until rx is first seen low after being high. If that first low level is captured at clock edge E, the first sample_valid starts at edge E + (cfg_prop+cfg_ph1+3)*(cfg_brp+1) + 2.
- R4: A falling rx edge seen in the propagation segment or phase 1 lengthens phase 1 by min(e, cfg_sjw+1) quanta. Here e is 1 plus the index of the current quantum, counted from 0 at the first propagation quantum.
- R5: A falling rx edge seen in phase-2 quantum q (q counted from 0) shortens phase 2 by min(cfg_ph2-q, cfg_sjw+1) quanta, so the bit ends no earlier than the end of the current quantum.
- R6: At most one synchronization takes effect per bit period. A hard synchronization counts as that bit's synchronization, and a falling edge in the sync segment consumes it without any adjustment.
- R7: With single sampling (cfg_smp=0), sample_bit is the rx level captured at the sample point edge.
- R8: With cfg_smp=1, sample_bit is the majority of the rx levels captured at the edge before the sample point, at the sample point and at the edge after it.
- R9: When cfg_brp is 0, triple sampling is forced off and single sampling is used, and cfg_error is 1.
- R10: cfg_error is 1 exactly when the captured cfg_brp or the captured cfg_ph2 is 0. It follows the configuration inputs with one cycle of latency while the block is disabled.
- R11: Configuration inputs are captured only while enable is 0. Changes while enabled have no effect on timing, sampling or cfg_error.
- R12: While enable is 0, and in reset, sample_valid stays 0 and the bit grid is dropped. After enable rises again, a new hard synchronization edge is needed before any sample_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the bit timer; 0 allows configuration capture |
| cfg_brp | input | BRP_W | Prescaler value, quantum = cfg_brp+1 clocks |
| cfg_prop | input | SEG_W | Propagation segment length minus one, in quanta |
| cfg_ph1 | input | SEG_W | Phase segment 1 length minus one, in quanta |
| cfg_ph2 | input | SEG_W | Phase segment 2 length minus one, in quanta |
| cfg_sjw | input | SJW_W | Jump width minus one, in quanta |
| cfg_smp | input | 1 | 1 selects three-sample majority |
| rx | input | 1 | Raw receive line, 1 = recessive |
| sample_valid | output | 1 | One-cycle strobe per received bit |
| sample_bit | output | 1 | Sampled bit value |
| cfg_error | output | 1 | Captured configuration is illegal |

## Verification
Checks on every cycle cover several rules. The strobe is a single-cycle pulse and is never raised while disabled. The captured configuration holds still while the block is enabled. The timer leaves idle only on a falling receive edge. The stretched phase-1 limit and the trimmed phase-2 limit stay within one jump width of their nominal values. Other behaviours can only be shown by the bench's timed scenarios: the exact strobe cycles, the amount of each lengthening or shortening with and without clamping, that a second edge in one bit is ignored, and the majority result for glitches placed on individual samples.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;

  typedef enum logic [2:0] {
    SEG_IDLE,
    SEG_SYNC,
    SEG_PROP,
    SEG_PH1,
    SEG_PH2
  } seg_t;

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/can_bt_cfg_hold.sv
module can_bt_cfg_hold #(
  parameter int BRP_W = 7,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [BRP_W-1:0] in_brp,
  input  logic [SEG_W-1:0] in_prop,
  input  logic [SEG_W-1:0] in_ph1,
  input  logic [SEG_W-1:0] in_ph2,
  input  logic [SJW_W-1:0] in_sjw,
  input  logic             in_smp,
  output logic [BRP_W-1:0] q_brp,
  output logic [SEG_W-1:0] q_prop,
  output logic [SEG_W-1:0] q_ph1,
  output logic [SEG_W-1:0] q_ph2,
  output logic [SJW_W-1:0] q_sjw,
  output logic             q_triple,
  output logic             q_error
);

  // Capture only while the timer is stopped; enabled writes are dropped.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_brp    <= '0;
      q_prop   <= '0;
      q_ph1    <= '0;
      q_ph2    <= '0;
      q_sjw    <= '0;
      q_triple <= 1'b0;
      q_error  <= 1'b0;
    end else if (!enable) begin
      q_brp    <= in_brp;
      q_prop   <= in_prop;
      q_ph1    <= in_ph1;
      q_ph2    <= in_ph2;
      q_sjw    <= in_sjw;
      q_triple <= in_smp && (in_brp != '0);
      q_error  <= (in_brp == '0) || (in_ph2 == '0);
    end
  end

endmodule

// File: rtl/can_bt_prescaler.sv
module can_bt_prescaler #(
  parameter int BRP_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hold,
  input  logic [BRP_W-1:0] div,
  output logic             tick
);

  logic [BRP_W-1:0] pcnt;

  assign tick = !hold && (pcnt == div);

  always_ff @(posedge clk) begin
    if (rst || hold || tick) pcnt <= '0;
    else                     pcnt <= pcnt + 1'b1;
  end

endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
  import can_bt_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic enable,
  input  logic rx,
  input  logic strobe,
  input  logic triple,
  output logic fall,
  output logic sample_valid,
  output logic sample_bit
);

  logic rx_q, rx_qq, sp_d;

  assign fall = rx_qq & ~rx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q         <= 1'b1;
      rx_qq        <= 1'b1;
      sp_d         <= 1'b0;
      sample_valid <= 1'b0;
      sample_bit   <= 1'b1;
    end else begin
      rx_q         <= rx;
      rx_qq        <= rx_q;
      sp_d         <= strobe && enable;
      sample_valid <= sp_d && enable;
      // rx_qq, rx_q and rx are the levels at sample point -1, 0 and +1.
      if (sp_d && enable)
        sample_bit <= triple ? vote3(rx, rx_q, rx_qq) : rx_q;
    end
  end

endmodule

// File: rtl/can_bit_timer.sv
module can_bit_timer
  import can_bt_pkg::*;
#(
  parameter int BRP_W = 7,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic [BRP_W-1:0] cfg_brp,
  input  logic [SEG_W-1:0] cfg_prop,
  input  logic [SEG_W-1:0] cfg_ph1,
  input  logic [SEG_W-1:0] cfg_ph2,
  input  logic [SJW_W-1:0] cfg_sjw,
  input  logic             cfg_smp,
  input  logic             rx,
  output logic             sample_valid,
  output logic             sample_bit,
  output logic             cfg_error
);

  localparam int CNT_W = SEG_W + 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [BRP_W-1:0] sh_brp;
  logic [SEG_W-1:0] sh_prop, sh_ph1, sh_ph2;
  logic [SJW_W-1:0] sh_sjw;
  logic             sh_triple;

  seg_t             seg_q;
  logic [CNT_W-1:0] qcnt, ph1_lim, ph2_lim;
  logic             synced;
  logic             tick, fall, sp_cond;

  logic [CNT_W-1:0] jump, late_pos, late_err, late_amt, early_err, early_amt;

  can_bt_cfg_hold #(.BRP_W(BRP_W), .SEG_W(SEG_W), .SJW_W(SJW_W)) u_cfg (
    .clk(clk), .rst(rst), .enable(enable),
    .in_brp(cfg_brp), .in_prop(cfg_prop), .in_ph1(cfg_ph1),
    .in_ph2(cfg_ph2), .in_sjw(cfg_sjw), .in_smp(cfg_smp),
    .q_brp(sh_brp), .q_prop(sh_prop), .q_ph1(sh_ph1),
    .q_ph2(sh_ph2), .q_sjw(sh_sjw), .q_triple(sh_triple),
    .q_error(cfg_error)
  );

  can_bt_prescaler #(.BRP_W(BRP_W)) u_pre (
    .clk(clk), .rst(rst), .hold(seg_q == SEG_IDLE), .div(sh_brp), .tick(tick)
  );

  can_bt_sampler u_smp (
    .clk(clk), .rst(rst), .enable(enable), .rx(rx), .strobe(sp_cond),
    .triple(sh_triple), .fall(fall), .sample_valid(sample_valid),
    .sample_bit(sample_bit)
  );

  assign sp_cond = tick && (seg_q == SEG_PH1) && (qcnt == ph1_lim);

  // Phase error in quanta, clamped to the jump width.
  always_comb begin
    jump      = CNT_W'(sh_sjw) + ONE;
    late_pos  = (seg_q == SEG_PROP) ? qcnt : CNT_W'(sh_prop) + ONE + qcnt;
    late_err  = late_pos + ONE;
    late_amt  = (late_err > jump) ? jump : late_err;
    early_err = CNT_W'(sh_ph2) - qcnt;
    early_amt = (early_err > jump) ? jump : early_err;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      seg_q   <= SEG_IDLE;
      qcnt    <= '0;
      ph1_lim <= '0;
      ph2_lim <= '0;
      synced  <= 1'b0;
    end else if (seg_q == SEG_IDLE) begin
      if (fall) begin
        seg_q   <= SEG_SYNC;
        qcnt    <= '0;
        synced  <= 1'b1;
        ph1_lim <= CNT_W'(sh_ph1);
        ph2_lim <= CNT_W'(sh_ph2);
      end
    end else begin
      if (fall && !synced) begin
        synced <= 1'b1;
        if (seg_q == SEG_PROP || seg_q == SEG_PH1)
          ph1_lim <= CNT_W'(sh_ph1) + late_amt;
        else if (seg_q == SEG_PH2)
          ph2_lim <= CNT_W'(sh_ph2) - early_amt;
      end
      if (tick) begin
        case (seg_q)
          SEG_SYNC: begin
            seg_q <= SEG_PROP;
            qcnt  <= '0;
          end
          SEG_PROP: begin
            if (qcnt == CNT_W'(sh_prop)) begin
              seg_q <= SEG_PH1;
              qcnt  <= '0;
            end else qcnt <= qcnt + ONE;
          end
          SEG_PH1: begin
            if (qcnt == ph1_lim) begin
              seg_q <= SEG_PH2;
              qcnt  <= '0;
            end else qcnt <= qcnt + ONE;
          end
          SEG_PH2: begin
            if (qcnt == ph2_lim) begin
              seg_q   <= SEG_SYNC;
              qcnt    <= '0;
              synced  <= 1'b0;
              ph1_lim <= CNT_W'(sh_ph1);
              ph2_lim <= CNT_W'(sh_ph2);
            end else qcnt <= qcnt + ONE;
          end
          default: seg_q <= SEG_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/can_bt_chk.sv
module can_bt_chk
  import can_bt_pkg::*;
#(
  parameter int BRP_W = 7,
  parameter int SEG_W = 3,
  parameter int SJW_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             sample_valid,
  input logic             fall,
  input seg_t             seg_q,
  input logic [SEG_W+1:0] ph1_lim,
  input logic [SEG_W+1:0] ph2_lim,
  input logic [BRP_W-1:0] sh_brp,
  input logic [SEG_W-1:0] sh_ph1,
  input logic [SEG_W-1:0] sh_ph2,
  input logic [SJW_W-1:0] sh_sjw
);

  a_r2_strobe_single: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  a_r12_quiet_disabled: assert property (@(posedge clk) disable iff (rst)
    !enable |=> !sample_valid);

  a_r3_leave_idle_on_edge: assert property (@(posedge clk) disable iff (rst)
    (seg_q != SEG_IDLE && $past(seg_q) == SEG_IDLE) |-> $past(fall));

  a_r4_ph1_stretch_bound: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_PH1) |->
      (int'(ph1_lim) >= int'(sh_ph1)) &&
      (int'(ph1_lim) <= int'(sh_ph1) + int'(sh_sjw) + 1));

  a_r5_ph2_trim_bound: assert property (@(posedge clk) disable iff (rst)
    (seg_q == SEG_PH2) |->
      (int'(ph2_lim) <= int'(sh_ph2)) &&
      (int'(ph2_lim) + int'(sh_sjw) + 1 >= int'(sh_ph2)));

  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    (enable && $past(enable)) |->
      ($stable(sh_brp) && $stable(sh_ph1) && $stable(sh_ph2) && $stable(sh_sjw)));

endmodule

bind can_bit_timer can_bt_chk #(.BRP_W(BRP_W), .SEG_W(SEG_W), .SJW_W(SJW_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .sample_valid(sample_valid),
  .fall(fall), .seg_q(seg_q), .ph1_lim(ph1_lim), .ph2_lim(ph2_lim),
  .sh_brp(sh_brp), .sh_ph1(sh_ph1), .sh_ph2(sh_ph2), .sh_sjw(sh_sjw)
);

// File: tb/sim_can_bit_timer.sv
module sim_can_bit_timer;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst, enable, rx, cfg_smp;
  logic [6:0] cfg_brp;
  logic [2:0] cfg_prop, cfg_ph1, cfg_ph2;
  logic [1:0] cfg_sjw;
  logic       sample_valid, sample_bit, cfg_error;

  can_bit_timer u0 (
    .clk(clk), .rst(rst), .enable(enable), .cfg_brp(cfg_brp),
    .cfg_prop(cfg_prop), .cfg_ph1(cfg_ph1), .cfg_ph2(cfg_ph2),
    .cfg_sjw(cfg_sjw), .cfg_smp(cfg_smp), .rx(rx),
    .sample_valid(sample_valid), .sample_bit(sample_bit), .cfg_error(cfg_error)
  );

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int total = 0, bad = 0, nvalid = 0;
  bit finished = 0;
  int    q_cyc[$];
  logic  q_bit[$];
  string q_tag[$];

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic expect_bit(string tag, int at, logic b);
    q_cyc.push_back(at);
    q_bit.push_back(b);
    q_tag.push_back(tag);
  endtask

  task automatic wait_to(int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic set_rx_at(int n, logic v);
    wait_to(n);
    rx = v;
  endtask

  task automatic set_cfg(int brp, int prop, int ph1, int ph2, int sjw, logic smp);
    cfg_brp = 7'(brp); cfg_prop = 3'(prop); cfg_ph1 = 3'(ph1);
    cfg_ph2 = 3'(ph2); cfg_sjw = 2'(sjw); cfg_smp = smp;
  endtask

  task automatic report();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // Monitor: pops one expected bit per strobe.
  always @(negedge clk) begin
    if (!rst && sample_valid) begin
      nvalid++;
      if (q_cyc.size() == 0) begin
        total++; bad++;
        $display("FAIL R12 unexpected strobe: actual=cycle %0d expected=none", cyc);
      end else begin
        int    ec;
        logic  eb;
        string et;
        ec = q_cyc.pop_front();
        eb = q_bit.pop_front();
        et = q_tag.pop_front();
        check({et, " strobe cycle"}, cyc, ec);
        check({et, " bit value"}, int'(sample_bit), int'(eb));
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      report();
    end
  end

  initial begin
    int q, sp_off, blen, h, c0, n0, s4, s5, s6, s7, s8;
    rst = 1'b1; enable = 1'b0; rx = 1'b1;
    set_cfg(3, 1, 2, 3, 1, 1'b0);
    repeat (5) @(negedge clk);
    check("R12 reset strobe", int'(sample_valid), 0);
    check("R10 reset error", int'(cfg_error), 0);
    rst = 1'b0;

    // ---- Scenario A: single sampling, resync cases ----
    q = 4; sp_off = (1 + 2 + 3) * q + 1; blen = (1 + 2 + 3 + 4) * q;
    n0 = nvalid;
    set_rx_at(cyc + 3, 1'b0);          // edges while disabled
    set_rx_at(cyc + 6, 1'b1);
    repeat (10) @(negedge clk);
    check("R12 disabled edges give no strobe", nvalid - n0, 0);
    check("R10 legal config", int'(cfg_error), 0);
    enable = 1'b1;
    @(negedge clk);
    set_cfg(9, 5, 5, 0, 3, 1'b1);      // ignored while enabled (R11)
    repeat (30) @(negedge clk);
    check("R3 no strobe before hard sync", nvalid - n0, 0);
    check("R11 error flag unaffected", int'(cfg_error), 0);
    c0 = cyc + 2;
    h = c0 + 2;
    expect_bit("R3 first bit", h + sp_off, 1'b0);
    expect_bit("R1 nominal period", h + blen + sp_off, 1'b1);
    expect_bit("R4 R6 late edge", h + 2 * blen + q + sp_off, 1'b0);
    expect_bit("R2 after stretch", h + 3 * blen + q + sp_off, 1'b0);
    s4 = h + 4 * blen + q;
    expect_bit("R11 old timing kept", s4 + sp_off, 1'b1);
    s5 = s4 + blen - q;
    expect_bit("R5 early edge", s5 + sp_off, 1'b0);
    s6 = s5 + blen;
    expect_bit("R1 after trim", s6 + sp_off, 1'b1);
    s7 = s6 + blen;
    expect_bit("R4 clamped stretch", s7 + sp_off + 2 * q, 1'b0);
    s8 = s7 + blen + 2 * q;
    expect_bit("R2 after clamp", s8 + sp_off, 1'b0);
    set_rx_at(c0, 1'b0);
    set_rx_at(h + blen, 1'b1);
    set_rx_at(h + 2 * blen + q, 1'b0);          // propagation quantum 0
    set_rx_at(h + 2 * blen + 3 * q, 1'b1);      // second edge, same bit
    set_rx_at(h + 2 * blen + 3 * q + 2, 1'b0);
    set_rx_at(s4, 1'b1);
    set_rx_at(s4 + sp_off - 1 + 2 * q, 1'b0);   // phase-2 quantum 2
    set_rx_at(s6, 1'b1);
    set_rx_at(s7 + 4 * q, 1'b0);                // phase-1 quantum 1
    wait_to(s8 + 32);
    enable = 1'b0;
    n0 = nvalid;
    repeat (60) @(negedge clk);
    check("R12 no strobe after disable", nvalid - n0, 0);
    check("R10 phase2 zero flagged", int'(cfg_error), 1);

    // ---- Scenario B: triple sampling ----
    rx = 1'b1;
    set_cfg(3, 1, 2, 3, 1, 1'b1);
    repeat (5) @(negedge clk);
    check("R10 error cleared", int'(cfg_error), 0);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    c0 = cyc + 2; h = c0 + 2;
    expect_bit("R8 single glitch outvoted", h + sp_off, 1'b0);
    expect_bit("R8 two-of-three", h + blen + sp_off, 1'b1);
    set_rx_at(c0, 1'b0);
    set_rx_at(h + sp_off - 2, 1'b1);
    set_rx_at(h + sp_off - 1, 1'b0);
    set_rx_at(h + blen + sp_off - 3, 1'b1);
    set_rx_at(h + blen + sp_off - 1, 1'b0);
    wait_to(h + blen + sp_off + 5);
    enable = 1'b0;

    // ---- Scenario C: single sampling with the same glitch ----
    rx = 1'b1;
    set_cfg(3, 1, 2, 3, 1, 1'b0);
    repeat (5) @(negedge clk);
    enable = 1'b1;
    repeat (5) @(negedge clk);
    c0 = cyc + 2; h = c0 + 2;
    expect_bit("R7 sample point level", h + sp_off, 1'b1);
    set_rx_at(c0, 1'b0);
    set_rx_at(h + sp_off - 2, 1'b1);
    set_rx_at(h + sp_off - 1, 1'b0);
    wait_to(h + sp_off + 5);
    enable = 1'b0;

    // ---- Scenario D: prescaler zero forces single sampling ----
    rx = 1'b1;
    set_cfg(0, 1, 2, 3, 1, 1'b1);
    repeat (5) @(negedge clk);
    check("R9 prescaler zero flagged", int'(cfg_error), 1);
    q = 1; sp_off = (1 + 2 + 3) * q + 1; blen = (1 + 2 + 3 + 4) * q;
    enable = 1'b1;
    repeat (5) @(negedge clk);
    c0 = cyc + 2; h = c0 + 2;
    expect_bit("R9 triple forced off", h + sp_off, 1'b1);
    expect_bit("R1 one-clock quantum", h + blen + sp_off, 1'b0);
    set_rx_at(c0, 1'b0);
    set_rx_at(h + sp_off - 2, 1'b1);
    set_rx_at(h + sp_off - 1, 1'b0);
    wait_to(h + blen + sp_off + 2);
    enable = 1'b0;

    // ---- Scenario E: re-enable without a new edge ----
    repeat (5) @(negedge clk);
    n0 = nvalid;
    enable = 1'b1;
    repeat (60) @(negedge clk);
    check("R12 re-enable needs hard sync", nvalid - n0, 0);
    enable = 1'b0;
    repeat (5) @(negedge clk);

    while (q_cyc.size() > 0) begin
      total++; bad++;
      $display("FAIL %s: actual=no strobe expected=cycle %0d", q_tag[0], q_cyc[0]);
      void'(q_cyc.pop_front());
      void'(q_bit.pop_front());
      void'(q_tag.pop_front());
    end
    report();
  end

endmodule